// File: doc/BRIEF.md
# Output Fault and Power-Good Supervisor

This block is the digital supervisor of a core-voltage buck regulator. Analog comparators report over-voltage, under-voltage, the upper and lower edges of the power-good window, and two die-temperature levels (hot and cooled down). The block receives these as raw single-bit signals and passes them through a two-stage synchronizer. It also reads the enable pin, a supply-good bit from the power-on-reset circuit, soft-start-done, a flag for a commanded VID transition, an external fault request, and the two gate requests from the PWM stage.

From these inputs it builds the gate commands sent to the drivers and drives an open-drain power-good output, modelled here as a pull-down enable. A sustained under-voltage or an external fault request sets a shutdown latch. Only a low level on enable or on supply-good clears it. Over-voltage works as a soft crowbar with no latch: it forces the low-side switch on for as long as the synchronized comparator stays high. Over-temperature stops switching until the cooled-down comparator reports, and then requests a fresh soft-start.

Top module: `core_fault_supervisor`

## Requirements
- R1: While and after reset, before any input changes, pg_pulldown_o is 1, and shutdown_o, temp_shut_o, gate_hi_o, gate_lo_o and ss_restart_o are all 0.
- R2: Each comparator input passes through two flops. A change on cmp_ov_i shows on the gate outputs after exactly two rising clock edges, and not after one.
- R3: The shutdown latch sets once cmp_uv_i, after synchronization, has been high on UV_HOLD consecutive qualifying edges. A shorter run never sets the latch.
- R4: Under-voltage is ignored while vid_moving_i is 1 or ss_done_i is 0. The qualifying count restarts whenever either condition holds.
- R5: Once set, shutdown_o stays 1 until en_i or supply_ok_i is sampled low. A sampled low clears it on that edge.
- R6: A 1 on ext_fault_i at a rising edge sets the shutdown latch, provided en_i and supply_ok_i are both 1.
- R7: While the synchronized over-voltage bit is 1, gate_lo_o is 1 and gate_hi_o is 0. This holds even when shut down. The command releases as soon as the bit falls, and it leaves no latch behind.
- R8: A synchronized hot bit sets temp_shut_o. temp_shut_o clears only on an edge where the cooled bit is 1 and the hot bit is 0. On that same edge ss_restart_o pulses high for exactly one cycle.
- R9: pg_pulldown_o is 0 only when running with no fault, ss_done_i is 1, over-voltage is clear, and the output is inside the window (both window bits 0) or a transition is flagged. Otherwise it is 1.
- R10: While vid_moving_i is 1, the window comparators have no effect on pg_pulldown_o.
- R11: When running with no shutdown, no over-temperature and no over-voltage, gate_hi_o follows pwm_hi_i and gate_lo_o follows pwm_lo_i. When shut down with over-voltage clear, both gates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable pin level; a low level clears the shutdown latch |
| supply_ok_i | input | 1 | Supply-good from power-on reset; a low level clears the shutdown latch |
| cmp_ov_i | input | 1 | Raw over-voltage comparator |
| cmp_uv_i | input | 1 | Raw under-voltage comparator (below 75 % of setpoint) |
| cmp_win_hi_i | input | 1 | Raw comparator, output above power-good upper limit |
| cmp_win_lo_i | input | 1 | Raw comparator, output below power-good lower limit |
| cmp_temp_hot_i | input | 1 | Raw die over-temperature comparator |
| cmp_temp_cool_i | input | 1 | Raw die cooled-down comparator |
| ss_done_i | input | 1 | Soft-start finished |
| vid_moving_i | input | 1 | Commanded voltage transition in progress |
| ext_fault_i | input | 1 | External request to latch shutdown |
| pwm_hi_i | input | 1 | High-side request from the modulator |
| pwm_lo_i | input | 1 | Low-side request from the modulator |
| pg_pulldown_o | output | 1 | 1 pulls the open-drain power-good line low |
| shutdown_o | output | 1 | Shutdown latch state |
| temp_shut_o | output | 1 | Over-temperature hold active |
| gate_hi_o | output | 1 | High-side gate command |
| gate_lo_o | output | 1 | Low-side gate command |
| ss_restart_o | output | 1 | One-cycle request for a new soft-start |

## Verification
The hardest case to reach is the exact boundary of the under-voltage filter. The stimulus must land on UV_HOLD − 1 qualifying edges versus UV_HOLD, after a two-flop delay, with the count restarted by transition masking. The bench builds the design with a small UV_HOLD and drives the raw comparator for a counted number of falling edges. It then samples the latch on the edge before and the edge after it should set. It reaches the over-voltage-with-latch priority case by first latching through the external request, and then raising over-voltage while the latch holds.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int CMP_W     = 6;
  localparam int IDX_OV    = 0;
  localparam int IDX_UV    = 1;
  localparam int IDX_WHI   = 2;
  localparam int IDX_WLO   = 3;
  localparam int IDX_THOT  = 4;
  localparam int IDX_TCOOL = 5;

  // Power-good condition apart from fault/run status.
  function automatic logic pg_condition(input logic ss_done, input logic moving,
                                        input logic win_hi, input logic win_lo);
    return ss_done & (moving | ~(win_hi | win_lo));
  endfunction

  // Under-voltage may be counted only outside transitions and after soft-start.
  function automatic logic uv_armed(input logic ss_done, input logic moving);
    return ss_done & ~moving;
  endfunction
endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/fsup_uv_qual.sv
module fsup_uv_qual #(
  parameter int HOLD = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic uv_i,
  input  logic arm_i,
  output logic trip_o
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;
  logic          qualify;

  assign qualify = uv_i & arm_i & ~clr_i;
  assign trip_o  = qualify & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!qualify || trip_o) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fsup_temp.sv
module fsup_temp (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic cool_i,
  output logic active_o,
  output logic restart_o
);
  logic release_now;
  assign release_now = active_o & ~hot_i & cool_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      restart_o <= 1'b0;
    end else begin
      restart_o <= release_now;
      if (hot_i)            active_o <= 1'b1;
      else if (release_now) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/core_fault_supervisor.sv
module core_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int UV_HOLD     = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic supply_ok_i,
  input  logic cmp_ov_i,
  input  logic cmp_uv_i,
  input  logic cmp_win_hi_i,
  input  logic cmp_win_lo_i,
  input  logic cmp_temp_hot_i,
  input  logic cmp_temp_cool_i,
  input  logic ss_done_i,
  input  logic vid_moving_i,
  input  logic ext_fault_i,
  input  logic pwm_hi_i,
  input  logic pwm_lo_i,
  output logic pg_pulldown_o,
  output logic shutdown_o,
  output logic temp_shut_o,
  output logic gate_hi_o,
  output logic gate_lo_o,
  output logic ss_restart_o
);
  logic [CMP_W-1:0] cmp_raw, cmp_s;
  logic ov_s, uv_s, whi_s, wlo_s, hot_s, cool_s;
  logic run_ok, latched, uv_trip, active, pg_ok;

  assign cmp_raw[IDX_OV]    = cmp_ov_i;
  assign cmp_raw[IDX_UV]    = cmp_uv_i;
  assign cmp_raw[IDX_WHI]   = cmp_win_hi_i;
  assign cmp_raw[IDX_WLO]   = cmp_win_lo_i;
  assign cmp_raw[IDX_THOT]  = cmp_temp_hot_i;
  assign cmp_raw[IDX_TCOOL] = cmp_temp_cool_i;

  fsup_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_raw), .q_o(cmp_s)
  );

  assign ov_s   = cmp_s[IDX_OV];
  assign uv_s   = cmp_s[IDX_UV];
  assign whi_s  = cmp_s[IDX_WHI];
  assign wlo_s  = cmp_s[IDX_WLO];
  assign hot_s  = cmp_s[IDX_THOT];
  assign cool_s = cmp_s[IDX_TCOOL];

  assign run_ok = en_i & supply_ok_i;

  fsup_uv_qual #(.HOLD(UV_HOLD)) u_uv (
    .clk(clk), .rst_n(rst_n), .clr_i(~run_ok | latched),
    .uv_i(uv_s), .arm_i(uv_armed(ss_done_i, vid_moving_i)), .trip_o(uv_trip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    latched <= 1'b0;
    else if (!run_ok)              latched <= 1'b0;
    else if (uv_trip | ext_fault_i) latched <= 1'b1;
  end

  fsup_temp u_temp (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_s), .cool_i(cool_s),
    .active_o(temp_shut_o), .restart_o(ss_restart_o)
  );

  assign active        = run_ok & ~latched & ~temp_shut_o;
  assign gate_hi_o     = active & pwm_hi_i & ~ov_s;
  assign gate_lo_o     = ov_s | (active & pwm_lo_i);
  assign pg_ok         = active & ~ov_s & pg_condition(ss_done_i, vid_moving_i, whi_s, wlo_s);
  assign pg_pulldown_o = ~pg_ok;
  assign shutdown_o    = latched;
endmodule

module fsup_checker (
  input logic clk,
  input logic rst_n,
  input logic run_ok,
  input logic latched,
  input logic uv_trip,
  input logic ov_s,
  input logic ss_done,
  input logic vid_moving,
  input logic ext_fault,
  input logic gate_hi,
  input logic gate_lo,
  input logic pg_pulldown,
  input logic ss_restart
);
  AST_OVP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ov_s |-> (gate_lo && !gate_hi)); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && run_ok) |=> latched); // R5
  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> !latched); // R5
  AST_UV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_moving || !ss_done) |-> !uv_trip); // R4
  AST_NO_SET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched && (vid_moving || !ss_done) && !ext_fault) |=> !latched); // R4
  AST_EXT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fault && run_ok) |=> latched); // R6
  AST_SHUT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !ov_s) |-> (!gate_hi && !gate_lo)); // R11
  AST_PG_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (latched || ov_s) |-> pg_pulldown); // R9
  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart); // R8
endmodule

bind core_fault_supervisor fsup_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .latched(latched),
  .uv_trip(uv_trip), .ov_s(ov_s), .ss_done(ss_done_i),
  .vid_moving(vid_moving_i), .ext_fault(ext_fault_i), .gate_hi(gate_hi_o),
  .gate_lo(gate_lo_o), .pg_pulldown(pg_pulldown_o), .ss_restart(ss_restart_o)
);

// File: tb/tb_core_fault_supervisor.sv
module tb_core_fault_supervisor;
  localparam int CLK_P = 10;
  localparam int HOLD  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i, supply_ok_i, cmp_ov_i, cmp_uv_i, cmp_win_hi_i, cmp_win_lo_i;
  logic cmp_temp_hot_i, cmp_temp_cool_i, ss_done_i, vid_moving_i, ext_fault_i;
  logic pwm_hi_i, pwm_lo_i;
  logic pg_pulldown_o, shutdown_o, temp_shut_o, gate_hi_o, gate_lo_o, ss_restart_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  core_fault_supervisor #(.SYNC_STAGES(2), .UV_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .supply_ok_i(supply_ok_i),
    .cmp_ov_i(cmp_ov_i), .cmp_uv_i(cmp_uv_i), .cmp_win_hi_i(cmp_win_hi_i),
    .cmp_win_lo_i(cmp_win_lo_i), .cmp_temp_hot_i(cmp_temp_hot_i),
    .cmp_temp_cool_i(cmp_temp_cool_i), .ss_done_i(ss_done_i),
    .vid_moving_i(vid_moving_i), .ext_fault_i(ext_fault_i),
    .pwm_hi_i(pwm_hi_i), .pwm_lo_i(pwm_lo_i), .pg_pulldown_o(pg_pulldown_o),
    .shutdown_o(shutdown_o), .temp_shut_o(temp_shut_o), .gate_hi_o(gate_hi_o),
    .gate_lo_o(gate_lo_o), .ss_restart_o(ss_restart_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    en_i = 1; supply_ok_i = 1; cmp_ov_i = 0; cmp_uv_i = 0; cmp_win_hi_i = 0;
    cmp_win_lo_i = 0; cmp_temp_hot_i = 0; cmp_temp_cool_i = 0; ss_done_i = 0;
    vid_moving_i = 0; ext_fault_i = 0; pwm_hi_i = 0; pwm_lo_i = 0;
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
    // R1 reset state
    chk("R1", "pg_pulldown", pg_pulldown_o, 1'b1);
    chk("R1", "shutdown", shutdown_o, 1'b0);
    chk("R1", "temp_shut", temp_shut_o, 1'b0);
    chk("R1", "gate_hi", gate_hi_o, 1'b0);
    chk("R1", "gate_lo", gate_lo_o, 1'b0);
    chk("R1", "ss_restart", ss_restart_o, 1'b0);

    // R11 pass-through sweep
    for (int p = 0; p < 4; p++) begin
      pwm_hi_i = p[1]; pwm_lo_i = p[0];
      #1;
      chk("R11", "gate_hi pass", gate_hi_o, p[1]);
      chk("R11", "gate_lo pass", gate_lo_o, p[0]);
      ticks(1);
    end

    // R9 / R10 power-good sweep over ss_done, moving, window bits
    for (int v = 0; v < 16; v++) begin
      ss_done_i = v[3]; vid_moving_i = v[2]; cmp_win_hi_i = v[1]; cmp_win_lo_i = v[0];
      ticks(2);
      chk(v[2] ? "R10" : "R9", "pg_pulldown sweep", pg_pulldown_o,
          !(v[3] && (v[2] || (!v[1] && !v[0]))));
    end
    ss_done_i = 1; vid_moving_i = 0; cmp_win_hi_i = 0; cmp_win_lo_i = 0;
    ticks(2);
    chk("R9", "pg good in window", pg_pulldown_o, 1'b0);

    // R2 / R7 over-voltage soft crowbar
    pwm_hi_i = 1; pwm_lo_i = 0;
    cmp_ov_i = 1;
    ticks(1);
    chk("R2", "gate_lo after one edge", gate_lo_o, 1'b0);
    ticks(1);
    chk("R2", "gate_lo after two edges", gate_lo_o, 1'b1);
    chk("R7", "gate_hi off in ov", gate_hi_o, 1'b0);
    chk("R9", "pg low in ov", pg_pulldown_o, 1'b1);
    cmp_ov_i = 0;
    ticks(2);
    chk("R7", "gate_lo released", gate_lo_o, 1'b0);
    chk("R7", "gate_hi resumed", gate_hi_o, 1'b1);
    chk("R7", "no latch from ov", shutdown_o, 1'b0);

    // R4 masking
    vid_moving_i = 1; cmp_uv_i = 1;
    ticks(HOLD + 10);
    chk("R4", "uv masked in transition", shutdown_o, 1'b0);
    vid_moving_i = 0; ss_done_i = 0;
    ticks(HOLD + 10);
    chk("R4", "uv masked before soft-start", shutdown_o, 1'b0);
    cmp_uv_i = 0; ss_done_i = 1;
    ticks(3);
    chk("R4", "no latch after unmask", shutdown_o, 1'b0);

    // R3 persistence boundary
    cmp_uv_i = 1;
    ticks(HOLD - 1);
    cmp_uv_i = 0;
    ticks(6);
    chk("R3", "short uv run ignored", shutdown_o, 1'b0);
    cmp_uv_i = 1;
    ticks(HOLD + 1);
    chk("R3", "latch one edge early", shutdown_o, 1'b0);
    ticks(1);
    chk("R3", "latch at hold", shutdown_o, 1'b1);
    pwm_hi_i = 1; pwm_lo_i = 1;
    #1;
    chk("R11", "gate_hi off when shut", gate_hi_o, 1'b0);
    chk("R11", "gate_lo off when shut", gate_lo_o, 1'b0);
    chk("R9", "pg low when shut", pg_pulldown_o, 1'b1);
    cmp_uv_i = 0;
    ticks(10);
    chk("R5", "latch holds", shutdown_o, 1'b1);
    en_i = 0;
    ticks(1);
    chk("R5", "enable low clears", shutdown_o, 1'b0);
    en_i = 1;
    #1;
    chk("R11", "gates resume", gate_hi_o & gate_lo_o, 1'b1);
    pwm_hi_i = 1; pwm_lo_i = 0;

    // R6 external request, R7 priority over latch, R5 supply cycling
    ext_fault_i = 1;
    ticks(1);
    ext_fault_i = 0;
    chk("R6", "external fault latches", shutdown_o, 1'b1);
    ticks(5);
    chk("R5", "still latched", shutdown_o, 1'b1);
    cmp_ov_i = 1;
    ticks(2);
    chk("R7", "ov priority over latch", gate_lo_o, 1'b1);
    chk("R7", "gate_hi off with latch", gate_hi_o, 1'b0);
    cmp_ov_i = 0;
    ticks(2);
    chk("R7", "release with latch", gate_lo_o, 1'b0);
    supply_ok_i = 0;
    ticks(1);
    chk("R5", "supply low clears", shutdown_o, 1'b0);
    supply_ok_i = 1;
    ticks(1);

    // R8 over-temperature with hysteresis
    cmp_temp_hot_i = 1;
    ticks(2);
    chk("R8", "temp not yet", temp_shut_o, 1'b0);
    ticks(1);
    chk("R8", "temp shut set", temp_shut_o, 1'b1);
    chk("R8", "gates off in temp", gate_hi_o, 1'b0);
    cmp_temp_hot_i = 0;
    ticks(10);
    chk("R8", "hold until cool", temp_shut_o, 1'b1);
    chk("R8", "no restart yet", ss_restart_o, 1'b0);
    cmp_temp_cool_i = 1;
    ticks(2);
    chk("R8", "restart not early", ss_restart_o, 1'b0);
    ticks(1);
    chk("R8", "restart pulse", ss_restart_o, 1'b1);
    chk("R8", "temp cleared", temp_shut_o, 1'b0);
    ticks(1);
    chk("R8", "pulse one cycle", ss_restart_o, 1'b0);
    chk("R11", "gate_hi after cool", gate_hi_o, 1'b1);

    finish_run();
  end
endmodule